// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned `WIDTH`-bit operand by another over several clock cycles. It returns the quotient, the remainder and a flag for a zero divisor. A one-cycle `start_i` pulse, given while the block is idle, captures both operands.

The block then runs one radix-2 step per clock. A signed partial remainder, one bit wider than the operands, and the quotient register shift left together. The sign of the partial remainder chooses whether the next step adds or subtracts the divisor, and the sign after that step gives the new quotient bit. No restore happens inside the loop. A single correction after the last step turns a negative partial remainder into the true remainder.

Results are registered and announced by a one-cycle `done_o` pulse. They stay on the outputs until the next operation completes. A parameter selects how the add/subtract unit is built: a behavioural adder or an explicit ripple-carry chain.

Top module: `seq_nr_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `div_by_zero_o` are 0, and `quotient_o` and `remainder_o` are all zeros.
- R2: A `start_i` sampled high at a rising edge while `busy_o` is low is accepted. `busy_o` is high from that edge until the edge that raises `done_o`.
- R3: For a nonzero divisor b and dividend a, the result gives `quotient_o` = floor(a/b) and `remainder_o` = a mod b. For example, 14 divided by 3 at WIDTH 4 gives quotient 4 and remainder 2.
- R4: For a nonzero divisor, `done_o` rises at the rising edge WIDTH+1 edges after the accepting edge. For a zero divisor, it rises one edge after the accepting edge.
- R5: For a divisor of 0, the result has `div_by_zero_o` = 1, `quotient_o` all ones and `remainder_o` equal to the dividend.
- R6: `done_o` is high for exactly one cycle, and `busy_o` is low while `done_o` is high.
- R7: A `start_i` sampled while `busy_o` is high is ignored. The running operation completes with its own operands and its own latency.
- R8: `quotient_o`, `remainder_o` and `div_by_zero_o` change only at an edge that raises `done_o`.
- R9: `div_by_zero_o` returns to 0 on the completion of a later operation with a nonzero divisor.
- R10: Both adder variants (`ADDER_KIND` 0 = behavioural, 1 = ripple-carry) give identical results and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| dividend_i | input | WIDTH | Unsigned dividend, sampled at the accepting edge |
| divisor_i | input | WIDTH | Unsigned divisor, sampled at the accepting edge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | WIDTH | Quotient (all ones on a zero divisor) |
| remainder_o | output | WIDTH | Remainder (dividend on a zero divisor) |
| div_by_zero_o | output | 1 | The last completed operation had a zero divisor |

## Verification
The assertions assume that operands count only at the edge that accepts `start_i`. The checker therefore records dividend and divisor at that edge alone, and checks latency and the quotient-times-divisor-plus-remainder identity against the recorded values. A `start_i` raised while busy is given different operands on purpose, so that a design which took them up would fail that identity. The sweep covers every operand pair at WIDTH 4, zero divisors included, with `start_i` held for exactly one cycle. A fresh operation starts only after each result has been held for several idle cycles.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } nrdiv_state_e;

   localparam int ADDER_BEHAV  = 0;
   localparam int ADDER_RIPPLE = 1;
endpackage

// File: rtl/nrdiv_addsub.sv
module nrdiv_addsub #(
   parameter int W          = 5,
   parameter int ADDER_KIND = 0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o
);
   import nrdiv_pkg::*;

   generate
      if (ADDER_KIND == ADDER_RIPPLE) begin : g_ripple
         logic [W:0]   carry;
         logic [W-1:0] b_eff;
         assign b_eff    = b_i ^ {W{sub_i}};
         assign carry[0] = sub_i;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1] = (a_i[i] & b_eff[i]) | (a_i[i] & carry[i]) | (b_eff[i] & carry[i]);
         end
      end else begin : g_behav
         assign sum_o = sub_i ? (a_i - b_i) : (a_i + b_i);
      end
   endgenerate
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic zero_div_i,
   output logic load_o,
   output logic step_o,
   output logic finish_o,
   output logic busy_o
);
   import nrdiv_pkg::*;

   localparam int          CW   = $clog2(WIDTH);
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   nrdiv_state_e  state_q;
   logic [CW-1:0] cnt_q;

   assign load_o   = (state_q == ST_IDLE) && start_i;
   assign step_o   = (state_q == ST_RUN);
   assign finish_o = (state_q == ST_FIX);
   assign busy_o   = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  cnt_q   <= '0;
                  state_q <= zero_div_i ? ST_FIX : ST_RUN;
               end
            end
            ST_RUN: begin
               if (cnt_q == LAST) state_q <= ST_FIX;
               else               cnt_q   <= cnt_q + 1'b1;
            end
            ST_FIX:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nrdiv_iter.sv
module nrdiv_iter #(
   parameter int WIDTH      = 8,
   parameter int ADDER_KIND = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [WIDTH-1:0] dividend_i,
   input  logic [WIDTH-1:0] divisor_i,
   output logic [WIDTH:0]   prem_o,
   output logic [WIDTH-1:0] quo_o,
   output logic [WIDTH-1:0] dsr_o,
   output logic             zero_o
);
   localparam int PW = WIDTH + 1;

   logic [PW-1:0]    prem_q;
   logic [WIDTH-1:0] quo_q;
   logic [WIDTH-1:0] dsr_q;
   logic             zero_q;
   logic [PW-1:0]    shifted;
   logic [PW-1:0]    next_prem;

   // Shift the remainder/quotient pair left; the sign before the step picks the operation.
   assign shifted = {prem_q[WIDTH-1:0], quo_q[WIDTH-1]};

   nrdiv_addsub #(.W(PW), .ADDER_KIND(ADDER_KIND)) u_step_adder (
      .a_i   (shifted),
      .b_i   ({1'b0, dsr_q}),
      .sub_i (~prem_q[WIDTH]),
      .sum_o (next_prem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prem_q <= '0;
         quo_q  <= '0;
         dsr_q  <= '0;
         zero_q <= 1'b0;
      end else if (load_i) begin
         prem_q <= '0;
         quo_q  <= dividend_i;
         dsr_q  <= divisor_i;
         zero_q <= (divisor_i == '0);
      end else if (step_i) begin
         prem_q <= next_prem;
         quo_q  <= {quo_q[WIDTH-2:0], ~next_prem[WIDTH]};
      end
   end

   assign prem_o = prem_q;
   assign quo_o  = quo_q;
   assign dsr_o  = dsr_q;
   assign zero_o = zero_q;
endmodule

// File: rtl/nrdiv_fixup.sv
module nrdiv_fixup #(
   parameter int WIDTH      = 8,
   parameter int ADDER_KIND = 0
) (
   input  logic [WIDTH:0]   prem_i,
   input  logic [WIDTH-1:0] dsr_i,
   output logic [WIDTH-1:0] rem_o
);
   localparam int PW = WIDTH + 1;

   logic [PW-1:0] restored;

   nrdiv_addsub #(.W(PW), .ADDER_KIND(ADDER_KIND)) u_fix_adder (
      .a_i   (prem_i),
      .b_i   ({1'b0, dsr_i}),
      .sub_i (1'b0),
      .sum_o (restored)
   );

   // One correction only: a negative final partial remainder gets the divisor back.
   assign rem_o = prem_i[WIDTH] ? restored[WIDTH-1:0] : prem_i[WIDTH-1:0];
endmodule

// File: rtl/seq_nr_divider.sv
module seq_nr_divider #(
   parameter int WIDTH      = 8,
   parameter int ADDER_KIND = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [WIDTH-1:0] dividend_i,
   input  logic [WIDTH-1:0] divisor_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] quotient_o,
   output logic [WIDTH-1:0] remainder_o,
   output logic             div_by_zero_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_nr_divider: WIDTH must be at least 2");
      end
      if (ADDER_KIND != 0 && ADDER_KIND != 1) begin : g_bad_kind
         $error("seq_nr_divider: ADDER_KIND must be 0 or 1");
      end
   endgenerate

   logic             load, step, finish;
   logic [WIDTH:0]   prem;
   logic [WIDTH-1:0] quo, dsr, rem;
   logic             zero_st;

   nrdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .zero_div_i (divisor_i == '0),
      .load_o     (load),
      .step_o     (step),
      .finish_o   (finish),
      .busy_o     (busy_o)
   );

   nrdiv_iter #(.WIDTH(WIDTH), .ADDER_KIND(ADDER_KIND)) u_iter (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .step_i     (step),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .prem_o     (prem),
      .quo_o      (quo),
      .dsr_o      (dsr),
      .zero_o     (zero_st)
   );

   nrdiv_fixup #(.WIDTH(WIDTH), .ADDER_KIND(ADDER_KIND)) u_fixup (
      .prem_i (prem),
      .dsr_i  (dsr),
      .rem_o  (rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o        <= 1'b0;
         quotient_o    <= '0;
         remainder_o   <= '0;
         div_by_zero_o <= 1'b0;
      end else begin
         done_o <= finish;
         if (finish) begin
            div_by_zero_o <= zero_st;
            if (zero_st) begin
               quotient_o  <= '1;
               remainder_o <= quo;   // quotient register still holds the dividend
            end else begin
               quotient_o  <= quo;
               remainder_o <= rem;
            end
         end
      end
   end
endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [WIDTH-1:0] dividend_i,
   input logic [WIDTH-1:0] divisor_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [WIDTH-1:0] quotient_o,
   input logic [WIDTH-1:0] remainder_o,
   input logic             div_by_zero_o
);
   localparam int LW = $clog2(WIDTH + 3) + 1;
   localparam int XW = 2 * WIDTH;

   logic [WIDTH-1:0] cap_a, cap_b;
   logic [LW-1:0]    lat_q;
   logic [XW-1:0]    recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_a <= '0;
         cap_b <= '0;
         lat_q <= '0;
      end else if (start_i && !busy_o) begin
         cap_a <= dividend_i;
         cap_b <= divisor_i;
         lat_q <= LW'(1);
      end else if (busy_o) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   assign recon = XW'(quotient_o) * XW'(cap_b) + XW'(remainder_o);

   a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);

   a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> lat_q == (div_by_zero_o ? LW'(2) : LW'(WIDTH + 2)));

   a_r3_exact_division: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !div_by_zero_o |-> (remainder_o < cap_b) && (recon == XW'(cap_a)));

   a_r5_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && div_by_zero_o |-> (cap_b == '0) && (quotient_o == '1) && (remainder_o == cap_a));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r6_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(quotient_o) && $stable(remainder_o) && $stable(div_by_zero_o));
endmodule

bind seq_nr_divider nrdiv_checker #(.WIDTH(WIDTH)) u_nrdiv_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .dividend_i    (dividend_i),
   .divisor_i     (divisor_i),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .quotient_o    (quotient_o),
   .remainder_o   (remainder_o),
   .div_by_zero_o (div_by_zero_o)
);

// File: tb/seq_nr_divider_bench.sv
`timescale 1ns/1ps
module seq_nr_divider_bench;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         busy0, done0, dbz0, busy1, done1, dbz1;
   logic [W-1:0] q0, r0, q1, r1;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   seq_nr_divider #(.WIDTH(W), .ADDER_KIND(0)) u_seq_nr_divider (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dividend_i(a_in), .divisor_i(b_in),
      .busy_o(busy0), .done_o(done0), .quotient_o(q0), .remainder_o(r0), .div_by_zero_o(dbz0));

   seq_nr_divider #(.WIDTH(W), .ADDER_KIND(1)) u_seq_nr_divider_rc (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dividend_i(a_in), .divisor_i(b_in),
      .busy_o(busy1), .done_o(done1), .quotient_o(q1), .remainder_o(r1), .div_by_zero_o(dbz1));

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // inject: raise start with other operands while busy (R7)
   task automatic run_op(input int a, input int b, input bit inject);
      int lat;
      int exp_q, exp_r, exp_lat;
      logic [W-1:0] hq, hr;
      @(negedge clk);
      a_in  = W'(a);
      b_in  = W'(b);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat   = 1;
      chk(busy0 == 1'b1, "R2", "busy after accepted start", int'(busy0), 1);
      while (!done0 && lat < 40) begin
         if (inject && lat == 2) begin
            a_in  = W'(a) ^ W'(5);
            b_in  = W'(b) ^ W'(3);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         if (!done0 && busy0 == 1'b0) chk(1'b0, "R2", "busy dropped early", 0, 1);
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      if (b == 0) begin
         exp_q = (1 << W) - 1; exp_r = a; exp_lat = 2;
      end else begin
         exp_q = a / b; exp_r = a % b; exp_lat = W + 2;
      end
      chk(lat == exp_lat, inject ? "R7" : "R4", "completion latency", lat, exp_lat);
      chk(int'(q0) == exp_q, b == 0 ? "R5" : (inject ? "R7" : "R3"), "quotient", int'(q0), exp_q);
      chk(int'(r0) == exp_r, b == 0 ? "R5" : (inject ? "R7" : "R3"), "remainder", int'(r0), exp_r);
      chk(dbz0 == (b == 0), b == 0 ? "R5" : "R9", "div_by_zero flag", int'(dbz0), int'(b == 0));
      chk(busy0 == 1'b0, "R6", "busy while done", int'(busy0), 0);
      chk(done1 == 1'b1 && q1 == q0 && r1 == r0 && dbz1 == dbz0, "R10", "ripple variant quotient",
          int'(q1), int'(q0));
      hq = q0; hr = r0;
      @(negedge clk);
      chk(done0 == 1'b0, "R6", "done pulse width", int'(done0), 0);
      @(negedge clk);
      @(negedge clk);
      chk(q0 == hq && r0 == hr, "R8", "held quotient", int'(q0), int'(hq));
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy0 == 0 && done0 == 0 && dbz0 == 0, "R1", "control outputs after reset",
          int'({busy0, done0, dbz0}), 0);
      chk(q0 == 0 && r0 == 0, "R1", "data outputs after reset", int'({q0, r0}), 0);

      // R3 worked example 14 / 3
      run_op(14, 3, 1'b0);
      // R5 then R9: zero divisor, followed by a nonzero one
      run_op(9, 0, 1'b0);
      run_op(9, 2, 1'b0);
      // R7: start during a running operation
      run_op(13, 2, 1'b1);
      run_op(15, 1, 1'b1);
      // Exhaustive sweep for R3 / R4 / R5 / R10
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            run_op(a, b, 1'b0);
         end
      end
      summary();
   end
endmodule